// File: doc/BRIEF.md
# Octal DAC Serial Control Core

This core is the digital side of an eight-channel digital-to-analog converter. A host drives three wires: a serial clock, a serial data line and a chip-select/load strobe. While the strobe is low, each rising serial clock edge samples one data bit into a 32-bit shift register. When the strobe rises, the last 24 bits shifted in are read as a command, a channel address and a data word, and the chosen operation is applied to the channel registers.

Each channel has two registers. The input register holds a staged code. The active register holds the code that drives the converter. Each channel also has a power-down flag. Commands can stage a code, copy staged codes to the active registers, or power a channel down. One address reaches all eight channels at once. The oldest bit in the shift register is presented on a serial output so that several devices can be chained. The serial clock and the strobe are brought into the system clock through synchronisers, so the serial clock may run at no more than a quarter of the system clock rate.

Top module: `octal_dac_ctrl`

## Requirements
- R1: A data bit is shifted in only on a rising serial clock edge while cs_ld is low. Serial clock edges while cs_ld is high change no state.
- R2: At the rising edge of cs_ld, the most recent 24 bits shifted in are decoded. Counting from the oldest, they are command[3:0], address[3:0] and data[15:0], each most significant bit first. Any earlier bits of a longer transfer, such as the 8 leading bits of a 32-bit frame, are ignored.
- R3: Codes and power-down flags change only as the result of a rising edge of cs_ld, or of a clear or reset.
- R4: Command 0000 writes the data into the input register of the addressed channel. The active code is left as it was.
- R5: Command 0001 copies the input register of the addressed channel into its active register and clears that channel's power-down flag.
- R6: Command 0010 writes the addressed input register and copies all eight input registers to their active registers, all on the same strobe. The addressed channel's active code takes the new data, and all eight power-down flags are cleared.
- R7: Command 0011 writes the data to both the input register and the active register of the addressed channel, and clears that channel's power-down flag.
- R8: Command 0100 sets the power-down flag of the addressed channel. The data word is ignored, and both of the channel's registers keep their contents.
- R9: Address values 0 to 7 select channels 0 to 7. Address 1111 selects all eight channels.
- R10: Command 1111, the commands 0101 to 1110, and the addresses 1000 to 1110 change no code and no flag.
- R11: While clr_n is low, all input registers, active codes and power-down flags are zero, without waiting for a clock edge. A synchronous low on rst_n clears the same state.
- R12: After each falling serial clock edge, sdo shows the oldest of the last 32 bits shifted in, which is the bit sampled 31 rising edges before the latest one.
- R13: The resolution parameter RES may be 16, 14 or 12. The code is data[15:16-RES], and the low 16-RES data bits are ignored.
- R14: all_pd is high exactly when all eight power-down flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | 1 | Asynchronous active-low clear of the channel state |
| sck | input | 1 | Serial clock, at most a quarter of the clk rate |
| sdi | input | 1 | Serial data in |
| cs_ld | input | 1 | Chip select, active low; its rising edge executes the frame |
| sdo | output | 1 | Serial data out for chaining |
| dac_codes | output | 8*RES | Active codes; channel c occupies bits [c*RES +: RES] |
| pd_flags | output | 8 | Power-down flag per channel |
| all_pd | output | 1 | High when every channel is powered down |

## Verification
The write-and-update-all command is the one operation where two functions land in one clock cycle. The addressed input register is loaded, and on the same edge all eight active registers copy from the input registers. The addressed channel must therefore take the new data and not the value it held before. The bench reaches this case in an exhaustive sweep over every command and address pair, with the staged values chosen to differ from the active ones. After each strobe it compares all eight codes against an arithmetic model that applies the write before the copy.

// File: rtl/octdac_pkg.sv
// Shared constants and operation codes for the octal DAC control core.
// Assumes a fixed count of eight channels, addressed by a 4-bit field.
package octdac_pkg;
    localparam int NUM_CH    = 8;
    localparam int ADDR_W    = $clog2(NUM_CH);
    localparam int SHIFT_LEN = 32;
    localparam int FRAME_LEN = 24;
    localparam int WORD_LEN  = 16;
    localparam int FIELD_W   = 4;

    typedef enum logic [FIELD_W-1:0] {
        OP_WRITE         = 4'b0000,
        OP_UPDATE        = 4'b0001,
        OP_WRITE_UPD_ALL = 4'b0010,
        OP_WRITE_UPD     = 4'b0011,
        OP_POWER_DOWN    = 4'b0100,
        OP_NOP           = 4'b1111
    } op_e;

    localparam logic [FIELD_W-1:0] ADDR_ALL = 4'b1111;
endpackage

// File: rtl/octdac_sync.sv
// Multi-flop synchroniser for one asynchronous input.
// Assumes the input is held for at least two system clocks between changes.
module octdac_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] pipe_q;

    // Move the input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= {pipe_q[STAGES-2:0], d_in};
    end

    assign q_out = pipe_q[STAGES-1];
endmodule

// File: rtl/octdac_shifter.sv
// 32-bit serial input register with a falling-edge serial output stage.
// Assumes shift_en and out_en are single-cycle strobes that are never high together.
module octdac_shifter
    import octdac_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 out_en,
    input  logic                 bit_in,
    output logic [FRAME_LEN-1:0] frame,
    output logic                 sdo
);
    logic [SHIFT_LEN-1:0] sh_q;
    logic                 sdo_q;

    // Shift on qualified rising serial clock; present the oldest bit on falling serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            sdo_q <= 1'b0;
        end else begin
            if (shift_en) sh_q  <= {sh_q[SHIFT_LEN-2:0], bit_in};
            if (out_en)   sdo_q <= sh_q[SHIFT_LEN-1];
        end
    end

    assign frame = sh_q[FRAME_LEN-1:0];
    assign sdo   = sdo_q;
endmodule

// File: rtl/octdac_decode.sv
// Turns a decoded frame into per-channel write, update and power-down strobes.
// Assumes ld_stb lasts one cycle; reserved codes produce no strobe at all.
module octdac_decode
    import octdac_pkg::*;
#(
    parameter int RES = 16
) (
    input  logic                 ld_stb,
    input  logic [FRAME_LEN-1:0] frame,
    output logic [NUM_CH-1:0]    wr_en,
    output logic [NUM_CH-1:0]    upd_en,
    output logic [NUM_CH-1:0]    pd_en,
    output logic [RES-1:0]       code
);
    logic [FIELD_W-1:0] cmd;
    logic [FIELD_W-1:0] addr;
    logic [NUM_CH-1:0]  sel;

    assign cmd  = frame[FRAME_LEN-1 -: FIELD_W];
    assign addr = frame[FRAME_LEN-FIELD_W-1 -: FIELD_W];
    assign code = frame[WORD_LEN-1 -: RES];

    // Address to channel mask: one channel, all channels, or none for reserved values.
    always_comb begin
        sel = '0;
        if (addr == ADDR_ALL)
            sel = '1;
        else if (addr < FIELD_W'(NUM_CH))
            sel[addr[ADDR_W-1:0]] = 1'b1;
    end

    // Command to strobe mapping; the write of 0010 and its global copy share one strobe.
    always_comb begin
        wr_en  = '0;
        upd_en = '0;
        pd_en  = '0;
        if (ld_stb) begin
            case (cmd)
                OP_WRITE:         wr_en = sel;
                OP_UPDATE:        upd_en = sel;
                OP_WRITE_UPD_ALL: begin
                    wr_en  = sel;
                    upd_en = (sel != '0) ? '1 : '0;
                end
                OP_WRITE_UPD:     begin
                    wr_en  = sel;
                    upd_en = sel;
                end
                OP_POWER_DOWN:    pd_en = sel;
                default:          ;
            endcase
        end
    end
endmodule

// File: rtl/octdac_channel.sv
// One channel: staged input register, active register and power-down flag.
// Assumes upd_en and pd_en are never high together; a write and an update on
// the same cycle pass the new data straight through to the active register.
module octdac_channel #(
    parameter int RES = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_n,
    input  logic           wr_en,
    input  logic           upd_en,
    input  logic           pd_en,
    input  logic [RES-1:0] code_in,
    output logic [RES-1:0] code_out,
    output logic           pd_out
);
    logic [RES-1:0] in_q;
    logic [RES-1:0] act_q;
    logic           pd_q;

    // Channel state with asynchronous clear and synchronous reset.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            in_q  <= '0;
            act_q <= '0;
            pd_q  <= 1'b0;
        end else if (!rst_n) begin
            in_q  <= '0;
            act_q <= '0;
            pd_q  <= 1'b0;
        end else begin
            if (wr_en) in_q <= code_in;
            if (upd_en) begin
                act_q <= wr_en ? code_in : in_q;
                pd_q  <= 1'b0;
            end else if (pd_en) begin
                pd_q  <= 1'b1;
            end
        end
    end

    assign code_out = act_q;
    assign pd_out   = pd_q;
endmodule

// File: rtl/octal_dac_ctrl.sv
// Serial control core for eight double-buffered DAC channels.
// Assumes sck runs at no more than a quarter of clk and sdi is stable around
// each rising sck; all three serial inputs pass through equal synchronisers.
module octal_dac_ctrl
    import octdac_pkg::*;
#(
    parameter int RES = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_n,
    input  logic                  sck,
    input  logic                  sdi,
    input  logic                  cs_ld,
    output logic                  sdo,
    output logic [NUM_CH*RES-1:0] dac_codes,
    output logic [NUM_CH-1:0]     pd_flags,
    output logic                  all_pd
);
    logic                 sck_s, sdi_s, cs_s;
    logic                 sck_d, cs_d;
    logic                 sck_rise, sck_fall, ld_stb, shift_en;
    logic [FRAME_LEN-1:0] frame;
    logic [NUM_CH-1:0]    wr_en, upd_en, pd_en;
    logic [RES-1:0]       code;

    octdac_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync_sck (
        .clk(clk), .rst_n(rst_n), .d_in(sck), .q_out(sck_s));
    octdac_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync_sdi (
        .clk(clk), .rst_n(rst_n), .d_in(sdi), .q_out(sdi_s));
    octdac_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .d_in(cs_ld), .q_out(cs_s));

    // Hold the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign ld_stb   = cs_s & ~cs_d;
    assign shift_en = sck_rise & ~cs_s;

    octdac_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .out_en(sck_fall),
        .bit_in(sdi_s), .frame(frame), .sdo(sdo));

    octdac_decode #(.RES(RES)) u_dec (
        .ld_stb(ld_stb), .frame(frame), .wr_en(wr_en), .upd_en(upd_en),
        .pd_en(pd_en), .code(code));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        octdac_channel #(.RES(RES)) u_ch (
            .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
            .wr_en(wr_en[c]), .upd_en(upd_en[c]), .pd_en(pd_en[c]),
            .code_in(code),
            .code_out(dac_codes[c*RES +: RES]),
            .pd_out(pd_flags[c]));
    end

    assign all_pd = &pd_flags;
endmodule

// File: rtl/octdac_checker.sv
// Temporal properties of the octal DAC control core, bound to the top module.
module octdac_checker #(
    parameter int RES = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           clr_n,
    input logic           ld_stb,
    input logic           shift_en,
    input logic           sck_fall,
    input logic [23:0]    frame,
    input logic           sdo,
    input logic [8*RES-1:0] dac_codes,
    input logic [7:0]     pd_flags
);
    p_frame_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(shift_en) |-> $stable(frame));

    p_codes_hold_r3: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        !$past(ld_stb) |-> ($stable(dac_codes) && $stable(pd_flags)));

    p_pd_set_by_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        ((pd_flags & ~$past(pd_flags)) != 8'h00) |->
            ($past(ld_stb) && $past(frame[23:20]) == 4'b0100));

    p_all_update_wakes_r6: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        ($past(ld_stb) && $past(frame[23:20]) == 4'b0010 && $past(frame[19:16]) == 4'b1111)
            |-> (pd_flags == 8'h00));

    p_reserved_noop_r10: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        ($past(ld_stb) && $past(frame[23:20]) >= 4'b0101 && $past(frame[23:20]) <= 4'b1110)
            |-> ($stable(dac_codes) && $stable(pd_flags)));

    p_sdo_on_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sck_fall) |-> $stable(sdo));

    p_clear_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (dac_codes == '0 && pd_flags == 8'h00));
endmodule

bind octal_dac_ctrl octdac_checker #(.RES(RES)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ld_stb(ld_stb),
    .shift_en(shift_en), .sck_fall(sck_fall), .frame(frame), .sdo(sdo),
    .dac_codes(dac_codes), .pd_flags(pd_flags));

// File: tb/octal_dac_ctrl_tb_top.sv
module octal_dac_ctrl_tb_top;
    localparam int RES = 12;
    localparam int NCH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_n = 1'b1;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic cs_ld = 1'b1;
    logic sdo;
    logic [NCH*RES-1:0] dac_codes;
    logic [NCH-1:0] pd_flags;
    logic all_pd;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [RES-1:0] m_in [NCH];
    logic [RES-1:0] m_act [NCH];
    logic [NCH-1:0] m_pd;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    octal_dac_ctrl #(.RES(RES)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sck(sck), .sdi(sdi),
        .cs_ld(cs_ld), .sdo(sdo), .dac_codes(dac_codes), .pd_flags(pd_flags),
        .all_pd(all_pd));

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic model_clear();
        for (int c = 0; c < NCH; c++) begin
            m_in[c] = '0;
            m_act[c] = '0;
        end
        m_pd = '0;
    endtask

    function automatic logic [15:0] next_rand(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // Model of one decoded frame, written from the requirements.
    task automatic model_apply(input logic [3:0] cmd, input logic [3:0] addr, input logic [15:0] data);
        logic [RES-1:0] cd;
        logic [NCH-1:0] sel;
        cd = data[15 -: RES];
        sel = '0;
        if (addr == 4'hF) sel = '1;
        else if (addr < 4'd8) sel[addr[2:0]] = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            if (sel[c]) begin
                case (cmd)
                    4'b0000: m_in[c] = cd;
                    4'b0001: begin m_act[c] = m_in[c]; m_pd[c] = 1'b0; end
                    4'b0010: m_in[c] = cd;
                    4'b0011: begin m_in[c] = cd; m_act[c] = cd; m_pd[c] = 1'b0; end
                    4'b0100: m_pd[c] = 1'b1;
                    default: ;
                endcase
            end
        end
        if (cmd == 4'b0010 && sel != '0) begin
            for (int c = 0; c < NCH; c++) begin
                m_act[c] = m_in[c];
                m_pd[c] = 1'b0;
            end
        end
    endtask

    task automatic check_state(input string tag);
        logic [NCH*RES-1:0] exp;
        for (int c = 0; c < NCH; c++) exp[c*RES +: RES] = m_act[c];
        total++;
        if (dac_codes !== exp) begin
            bad++;
            $display("FAIL %s codes: actual=%h expected=%h", tag, dac_codes, exp);
        end
        total++;
        if (pd_flags !== m_pd || all_pd !== (&m_pd)) begin
            bad++;
            $display("FAIL %s R14 flags: actual=%b/%b expected=%b/%b",
                     tag, pd_flags, all_pd, m_pd, &m_pd);
        end
    endtask

    // Send n bits, most significant first; optionally check sdo after each fall (R12).
    task automatic xfer(input logic [63:0] bits, input int n, input bit chk_sdo);
        cs_ld = 1'b0;
        #40;
        for (int k = 1; k <= n; k++) begin
            sdi = bits[n-k];
            #40 sck = 1'b1;
            #40 sck = 1'b0;
            if (chk_sdo && k >= 32) begin
                #40;
                total++;
                if (sdo !== bits[n-(k-31)]) begin
                    bad++;
                    $display("FAIL R12 sdo after edge %0d: actual=%b expected=%b",
                             k, sdo, bits[n-(k-31)]);
                end
            end
        end
        #40 cs_ld = 1'b1;
        #120;
    endtask

    function automatic string tag_of(input logic [3:0] cmd, input logic [3:0] addr);
        string t;
        case (cmd)
            4'b0000: t = "R4";
            4'b0001: t = "R5";
            4'b0010: t = "R6";
            4'b0011: t = "R7";
            4'b0100: t = "R8";
            default: t = "R10";
        endcase
        if (addr == 4'hF) t = {t, " R9"};
        else if (addr > 4'd7) t = {t, " R10"};
        return {t, " R1 R2 R3 R13"};
    endfunction

    task automatic do_frame(input logic [3:0] cmd, input logic [3:0] addr, input bit long_frame);
        logic [63:0] w;
        lfsr = next_rand(lfsr);
        w = {40'd0, cmd, addr, lfsr};
        if (long_frame) w = {32'd0, lfsr[7:0] ^ 8'hA5, cmd, addr, lfsr};
        xfer(w, long_frame ? 32 : 24, 1'b0);
        model_apply(cmd, addr, lfsr);
        check_state(tag_of(cmd, addr));
    endtask

    initial begin
        #1_500_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        model_clear();
        #50 rst_n = 1'b1;
        #40;
        check_state("R11 reset");
        total++;
        if (sdo !== 1'b0) begin
            bad++;
            $display("FAIL R12 reset sdo: actual=%b expected=0", sdo);
        end

        // Exhaustive sweep of every address and command; frame length alternates (R2).
        for (int a = 0; a < 16; a++) begin
            for (int c = 0; c < 16; c++) begin
                do_frame(4'(c), 4'(a), ((a + c) % 2) == 1);
            end
        end
        // Stage distinct values, then release with an update to one channel (R5, R14).
        do_frame(4'b0000, 4'hF, 1'b0);
        do_frame(4'b0001, 4'd3, 1'b0);
        do_frame(4'b0100, 4'd3, 1'b1);
        do_frame(4'b0000, 4'd5, 1'b0);
        do_frame(4'b0010, 4'd5, 1'b1);

        // R1: serial clocks with cs_ld high must not shift; an empty strobe re-runs the old frame.
        do_frame(4'b0000, 4'd6, 1'b0);
        begin
            logic [23:0] junk;
            logic sdo_before;
            junk = {4'b0011, 4'd6, 16'hFFF0};
            sdo_before = sdo;
            for (int k = 23; k >= 0; k--) begin
                sdi = junk[k];
                #40 sck = 1'b1;
                #40 sck = 1'b0;
            end
            #40 cs_ld = 1'b0;
            #80 cs_ld = 1'b1;
            #120;
            check_state("R1 ignored clocks");
            total++;
            if (sdo !== sdo_before) begin
                bad++;
                $display("FAIL R1 sdo moved: actual=%b expected=%b", sdo, sdo_before);
            end
        end

        // R12 and R2: a 64-bit transfer, with sdo checked at every fall after the 32nd.
        begin
            logic [63:0] w;
            w = {32'hC3A5_96F1, 8'h3C, 4'b0011, 4'd1, 16'h9ABC};
            xfer(w, 64, 1'b1);
            model_apply(4'b0011, 4'd1, 16'h9ABC);
            check_state("R2 R7 R12 long transfer");
        end

        // R11: asynchronous clear, observed between clock edges.
        #3 clr_n = 1'b0;
        #1;
        model_clear();
        check_state("R11 async clear");
        #46 clr_n = 1'b1;
        #50;
        check_state("R11 after clear");

        // R11: synchronous reset clears state written after the clear.
        do_frame(4'b0011, 4'd2, 1'b0);
        do_frame(4'b0100, 4'd4, 1'b0);
        rst_n = 1'b0;
        #30 rst_n = 1'b1;
        #40;
        model_clear();
        check_state("R11 sync reset");

        finish_run();
    end
endmodule